// File: doc/BRIEF.md
# Power-Management Event, Control and Timer Register Block

This block holds the fixed power-management registers that an operating system polls and programs through a small I/O window. It provides a sticky event-status register, an event-enable register, a control register, a free-running power-management timer and a one-byte command port. The timer counts ticks of an external rate strobe, nominally 3.579545 MHz. The block raises a level-sensitive system control interrupt (SCI) while any enabled event is pending. It emits a single-cycle soft-power-off request when software arms a suspend of type zero.

Host accesses use a single-cycle request: valid, write, a 6-bit offset, a size code and write data. Read data is registered and appears on `rd_data` one cycle after the read request. Writes take effect at the request's clock edge. The command port has its own write strobe and byte. It lets firmware switch the SCI-enable control bit on and off without a read-modify-write of the control register.

A two-state machine sequences the power-off request. `PWR_RUN` is the resting state. A 16-bit control write with bit 13 set and bits 12:10 equal to zero takes the machine from `PWR_RUN` to `PWR_OFF_PULSE`. `PWR_OFF_PULSE` drives `poweroff_req` for its single cycle and always returns to `PWR_RUN`. A request that arrives while in `PWR_OFF_PULSE` is absorbed, because the pulse is already being issued.

Top module: `pm_regblk`

## Requirements
- R1: After reset, status, enable and control read as 0x0000, the timer reads 0, and `sci` and `poweroff_req` are low.
- R2: Size codes on `bus_size` are 0 = byte, 1 = 16-bit, 2 = 32-bit. A 16-bit read at offset 0x00, 0x02 or 0x04 returns status, enable or control in bits 15:0. A 32-bit read at offset 0x08 returns the timer zero-extended. Any other offset or size reads 0. `rd_data` holds the result from the cycle after the request.
- R3: The timer (TMR_W bits, 24 by default) increments by one on each cycle with `tick_en` high, holds otherwise, and wraps to 0 after all ones.
- R4: Status bit 0 becomes set on the tick that changes the timer's most significant bit, whether that change is 0 to 1 or 1 to 0.
- R5: Status bit 10 is set by a pulse on `rtc_evt`, bit 8 by `pwrbtn_evt` and bit 5 by `gbl_evt`. A 16-bit write to 0x00 clears each bit written as 1 and leaves bits written as 0 unchanged. An event on a bit being cleared in the same cycle leaves that bit set. All other status bits read 0.
- R6: A 16-bit write to offset 0x02 stores all 16 bits into the enable register.
- R7: `sci` is high exactly while (status AND enable) has bit 10, 8, 5 or 0 set.
- R8: A 16-bit write to offset 0x04 stores every bit except bit 13. Bit 13 always reads 0.
- R9: A control write with bit 13 set and bits 12:10 equal to 0 raises `poweroff_req` for exactly one cycle, the cycle after the write. Any other value in bits 12:10 raises no request.
- R10: `smi_wr` with `smi_data` = 0xF1 sets control bit 0, and 0xF0 clears it. Any other byte leaves control unchanged.
- R11: 32-bit and byte writes to the register window change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer rate strobe, one count per high cycle |
| bus_valid | input | 1 | Host access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Offset within the register window |
| bus_size | input | 2 | Access size code: 0 byte, 1 16-bit, 2 32-bit |
| bus_wdata | input | 32 | Write data |
| smi_wr | input | 1 | Command port write strobe |
| smi_data | input | 8 | Command port byte |
| rtc_evt | input | 1 | Alarm event pulse, sets status bit 10 |
| pwrbtn_evt | input | 1 | Power button event pulse, sets status bit 8 |
| gbl_evt | input | 1 | Global-lock event pulse, sets status bit 5 |
| rd_data | output | 32 | Registered read data |
| sci | output | 1 | Level system control interrupt |
| poweroff_req | output | 1 | One-cycle soft-power-off request |

## Verification
Two functions can fall in the same cycle. An event pulse can set a status bit while a write-one-to-clear targets that same bit. The bench provokes this by asserting `pwrbtn_evt` in the very cycle that it writes 0x0100 to offset 0x00. It passes only if a later status read still shows bit 8 set. The power-off path is judged cycle by cycle: the bench samples `poweroff_req` one and two cycles after the arming write, and separately confirms that a nonzero suspend type never pulses it.

// File: rtl/pm_regblk_pkg.sv
package pm_regblk_pkg;

    // access size codes on bus_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // register offsets inside the window
    localparam logic [5:0] OFS_STS  = 6'h00;
    localparam logic [5:0] OFS_EN   = 6'h02;
    localparam logic [5:0] OFS_CTRL = 6'h04;
    localparam logic [5:0] OFS_TMR  = 6'h08;

    // status bit positions and the implemented-bit mask
    localparam int STS_TMR_BIT    = 0;
    localparam int STS_GBL_BIT    = 5;
    localparam int STS_PWRBTN_BIT = 8;
    localparam int STS_RTC_BIT    = 10;
    localparam logic [15:0] STS_MASK = 16'h0521;

    // control fields
    localparam int CTRL_SCIEN_BIT = 0;
    localparam int CTRL_SUSP_BIT  = 13;
    localparam int CTRL_TYP_LO    = 10;
    localparam int CTRL_TYP_HI    = 12;

    // command port codes
    localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
    localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

    typedef enum logic [0:0] {
        PWR_RUN       = 1'b0,
        PWR_OFF_PULSE = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] tmr_q,
    output logic             msb_flip
);
    localparam int LOW_W = TMR_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tick_en) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // the next tick carries into (or out of) the top bit
    assign msb_flip = tick_en && (&tmr_q[LOW_W-1:0]);

    // R3
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> tmr_q == TMR_W'($past(tmr_q) + 1'b1));

    // R3
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tmr_q));

endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
    import pm_regblk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sts_wr,
    input  logic        en_wr,
    input  logic [15:0] wdata,
    input  logic        rtc_evt,
    input  logic        pwrbtn_evt,
    input  logic        gbl_evt,
    input  logic        tmr_flip,
    output logic [15:0] sts_q,
    output logic [15:0] en_q,
    output logic        sci
);
    logic [15:0] set_vec;
    logic [15:0] clr_vec;
    logic [15:0] sts_d;

    always_comb begin
        set_vec                 = '0;
        set_vec[STS_RTC_BIT]    = rtc_evt;
        set_vec[STS_PWRBTN_BIT] = pwrbtn_evt;
        set_vec[STS_GBL_BIT]    = gbl_evt;
        set_vec[STS_TMR_BIT]    = tmr_flip;
        clr_vec                 = sts_wr ? wdata : 16'h0000;
        // setting after clearing lets an event win over a same-cycle clear
        sts_d                   = ((sts_q & ~clr_vec) | set_vec) & STS_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            if (en_wr) begin
                en_q <= wdata;
            end
        end
    end

    assign sci = |(sts_q & en_q & STS_MASK);

    // R5
    rtc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> sts_q[STS_RTC_BIT]);

    // R5
    pwrbtn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_evt |=> sts_q[STS_PWRBTN_BIT]);

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && set_vec == 16'h0000) |=> (sts_q & $past(wdata)) == 16'h0000);

    // R4
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_flip |=> sts_q[STS_TMR_BIT]);

    // R7
    sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 16'h0000) |-> !sci);

endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_regblk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [15:0] wdata,
    input  logic        smi_wr,
    input  logic [7:0]  smi_data,
    output logic [15:0] ctrl_q,
    output logic        poweroff_req
);
    pwr_state_e state_q;
    pwr_state_e state_d;
    logic       susp_req;

    assign susp_req = ctrl_wr && wdata[CTRL_SUSP_BIT]
                      && (wdata[CTRL_TYP_HI:CTRL_TYP_LO] == 3'b000);

    // control register; the command port acts after the bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q                <= wdata;
                ctrl_q[CTRL_SUSP_BIT] <= 1'b0;
            end
            if (smi_wr && smi_data == CMD_SCI_ON) begin
                ctrl_q[CTRL_SCIEN_BIT] <= 1'b1;
            end else if (smi_wr && smi_data == CMD_SCI_OFF) begin
                ctrl_q[CTRL_SCIEN_BIT] <= 1'b0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN:       if (susp_req) state_d = PWR_OFF_PULSE;
            PWR_OFF_PULSE: state_d = PWR_RUN;
            default:       state_d = PWR_RUN;
        endcase
    end

    // outputs
    always_comb begin
        poweroff_req = (state_q == PWR_OFF_PULSE);
    end

    // R9
    pwroff_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |=> !poweroff_req);

    // R9
    pwroff_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_req && state_q == PWR_RUN) |=> poweroff_req);

    // R10
    smi_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_wr && smi_data == CMD_SCI_ON) |=> ctrl_q[CTRL_SCIEN_BIT]);

    // R10
    smi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_wr && smi_data == CMD_SCI_OFF) |=> !ctrl_q[CTRL_SCIEN_BIT]);

endmodule

// File: rtl/pm_regblk.sv
module pm_regblk
    import pm_regblk_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [5:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    input  logic        smi_wr,
    input  logic [7:0]  smi_data,
    input  logic        rtc_evt,
    input  logic        pwrbtn_evt,
    input  logic        gbl_evt,
    output logic [31:0] rd_data,
    output logic        sci,
    output logic        poweroff_req
);
    localparam int DATA_W = 32;
    localparam int PAD_W  = DATA_W - TMR_W;

    logic             rd_req;
    logic             wr_half;
    logic             sts_wr;
    logic             en_wr;
    logic             ctrl_wr;
    logic [TMR_W-1:0] tmr_q;
    logic             tmr_flip;
    logic [15:0]      sts_q;
    logic [15:0]      en_q;
    logic [15:0]      ctrl_q;
    logic [31:0]      rd_mux;

    assign rd_req  = bus_valid && !bus_write;
    assign wr_half = bus_valid && bus_write && (bus_size == SZ_HALF);
    assign sts_wr  = wr_half && (bus_addr == OFS_STS);
    assign en_wr   = wr_half && (bus_addr == OFS_EN);
    assign ctrl_wr = wr_half && (bus_addr == OFS_CTRL);

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tmr_q    (tmr_q),
        .msb_flip (tmr_flip)
    );

    pm_evt_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_wr     (sts_wr),
        .en_wr      (en_wr),
        .wdata      (bus_wdata[15:0]),
        .rtc_evt    (rtc_evt),
        .pwrbtn_evt (pwrbtn_evt),
        .gbl_evt    (gbl_evt),
        .tmr_flip   (tmr_flip),
        .sts_q      (sts_q),
        .en_q       (en_q),
        .sci        (sci)
    );

    pm_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .wdata        (bus_wdata[15:0]),
        .smi_wr       (smi_wr),
        .smi_data     (smi_data),
        .ctrl_q       (ctrl_q),
        .poweroff_req (poweroff_req)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_size == SZ_HALF) begin
            unique case (bus_addr)
                OFS_STS:  rd_mux = {16'h0000, sts_q};
                OFS_EN:   rd_mux = {16'h0000, en_q};
                OFS_CTRL: rd_mux = {16'h0000, ctrl_q};
                default:  rd_mux = '0;
            endcase
        end else if (bus_size == SZ_WORD && bus_addr == OFS_TMR) begin
            rd_mux = {{PAD_W{1'b0}}, tmr_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= rd_mux;
        end
    end

    // R2
    tmr_rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_size == SZ_WORD && bus_addr == OFS_TMR)
        |=> (rd_data >> TMR_W) == 32'h0);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

    // R11
    wide_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != SZ_HALF) |=> $stable(en_q));

endmodule

// File: tb/pm_regblk_bench.sv
module pm_regblk_bench;
    localparam int TW = 10;
    localparam logic [2:0] OP_W16 = 3'd0;
    localparam logic [2:0] OP_R16 = 3'd1;
    localparam logic [2:0] OP_R32 = 3'd2;
    localparam logic [2:0] OP_SMI = 3'd3;
    localparam logic [2:0] OP_W32 = 3'd4;
    localparam logic [2:0] OP_W8  = 3'd5;
    localparam int NV = 19;

    // {op, offset, data-or-expected}
    localparam logic [40:0] TBL [NV] = '{
        {OP_W16, 6'h02, 32'h0000_0521},
        {OP_R16, 6'h02, 32'h0000_0521},  // R6
        {OP_W16, 6'h04, 32'h0000_1C07},
        {OP_R16, 6'h04, 32'h0000_1C07},  // R8
        {OP_W16, 6'h04, 32'h0000_3C06},
        {OP_R16, 6'h04, 32'h0000_1C06},  // R8 bit 13 dropped
        {OP_SMI, 6'h00, 32'h0000_00F1},
        {OP_R16, 6'h04, 32'h0000_1C07},  // R10 on
        {OP_SMI, 6'h00, 32'h0000_005A},
        {OP_R16, 6'h04, 32'h0000_1C07},  // R10 other byte
        {OP_SMI, 6'h00, 32'h0000_00F0},
        {OP_R16, 6'h04, 32'h0000_1C06},  // R10 off
        {OP_W32, 6'h02, 32'h0000_FFFF},
        {OP_R16, 6'h02, 32'h0000_0521},  // R11 word write
        {OP_W8,  6'h04, 32'h0000_00FF},
        {OP_R16, 6'h04, 32'h0000_1C06},  // R11 byte write
        {OP_R16, 6'h06, 32'h0000_0000},  // R2 empty offset
        {OP_R32, 6'h00, 32'h0000_0000},  // R2 wrong size
        {OP_R16, 6'h08, 32'h0000_0000}   // R2 wrong size
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        smi_wr = 1'b0;
    logic [7:0]  smi_data = '0;
    logic        rtc_evt = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        gbl_evt = 1'b0;
    logic [31:0] rd_data;
    logic        sci;
    logic        poweroff_req;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    pm_regblk #(.TMR_W(TW)) u_pm_regblk (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .smi_wr(smi_wr), .smi_data(smi_data),
        .rtc_evt(rtc_evt), .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt),
        .rd_data(rd_data), .sci(sci), .poweroff_req(poweroff_req)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (poweroff_req) pulses <= pulses + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] sz, input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic smi(input logic [7:0] b);
        @(negedge clk);
        smi_wr = 1'b1; smi_data = b;
        @(negedge clk);
        smi_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 sci", {31'b0, sci}, 32'h0);
        check("R1 poweroff_req", {31'b0, poweroff_req}, 32'h0);
        bus_rd(2'd1, 6'h00, rv); check("R1 status", rv, 32'h0);
        bus_rd(2'd1, 6'h02, rv); check("R1 enable", rv, 32'h0);
        bus_rd(2'd1, 6'h04, rv); check("R1 control", rv, 32'h0);
        bus_rd(2'd2, 6'h08, rv); check("R1 timer", rv, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [5:0]  a;
            logic [31:0] d;
            {op, a, d} = TBL[i];
            unique case (op)
                OP_W16: bus_wr(2'd1, a, d);
                OP_W32: bus_wr(2'd2, a, d);
                OP_W8:  bus_wr(2'd0, a, d);
                OP_SMI: smi(d[7:0]);
                OP_R16: begin bus_rd(2'd1, a, rv); check($sformatf("R2/R6/R8/R10/R11 row %0d", i), rv, d); end
                OP_R32: begin bus_rd(2'd2, a, rv); check($sformatf("R2 row %0d", i), rv, d); end
                default: ;
            endcase
        end
        check("R9 no pulse for type 7", pulses, 0);

        // R5/R7 event sets status, sci follows enable
        @(negedge clk); rtc_evt = 1'b1;
        @(negedge clk); rtc_evt = 1'b0;
        check("R7 sci on rtc", {31'b0, sci}, 32'h1);
        bus_rd(2'd1, 6'h00, rv); check("R5 rtc status", rv, 32'h0400);
        bus_wr(2'd1, 6'h00, 32'h0000);
        bus_rd(2'd1, 6'h00, rv); check("R5 write zero keeps", rv, 32'h0400);
        bus_wr(2'd1, 6'h00, 32'h0400);
        bus_rd(2'd1, 6'h00, rv); check("R5 w1c", rv, 32'h0);
        check("R7 sci drops", {31'b0, sci}, 32'h0);

        // R5 event wins over same-cycle clear
        @(negedge clk);
        pwrbtn_evt = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd1; bus_addr = 6'h00; bus_wdata = 32'h0100;
        @(negedge clk);
        pwrbtn_evt = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_rd(2'd1, 6'h00, rv); check("R5 event beats clear", rv, 32'h0100);
        bus_wr(2'd1, 6'h00, 32'hFFFF);

        // R7 masking by enable
        bus_wr(2'd1, 6'h02, 32'h0001);
        @(negedge clk); gbl_evt = 1'b1;
        @(negedge clk); gbl_evt = 1'b0;
        check("R7 masked sci", {31'b0, sci}, 32'h0);
        bus_rd(2'd1, 6'h00, rv); check("R5 gbl status", rv, 32'h0020);
        bus_wr(2'd1, 6'h02, 32'h0020);
        check("R7 sci after enable", {31'b0, sci}, 32'h1);
        bus_wr(2'd1, 6'h00, 32'h0020);
        check("R7 sci after clear", {31'b0, sci}, 32'h0);

        // R3/R4 timer and top-bit flag
        bus_wr(2'd1, 6'h02, 32'h0001);
        ticks(5);
        bus_rd(2'd2, 6'h08, rv); check("R3 five ticks", rv, 32'd5);
        ticks(506);
        bus_rd(2'd2, 6'h08, rv); check("R3 before flip", rv, 32'd511);
        bus_rd(2'd1, 6'h00, rv); check("R4 no flag yet", rv, 32'h0);
        ticks(1);
        bus_rd(2'd1, 6'h00, rv); check("R4 flag on rise", rv, 32'h0001);
        check("R7 sci on timer flag", {31'b0, sci}, 32'h1);
        bus_rd(2'd2, 6'h08, rv); check("R2 R3 timer zero-extended", rv, 32'd512);
        bus_wr(2'd1, 6'h00, 32'h0001);
        ticks(511);
        bus_rd(2'd1, 6'h00, rv); check("R4 no flag mid-span", rv, 32'h0);
        ticks(1);
        bus_rd(2'd2, 6'h08, rv); check("R3 wrap", rv, 32'd0);
        bus_rd(2'd1, 6'h00, rv); check("R4 flag on fall", rv, 32'h0001);

        // R9 power-off pulse timing
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd1; bus_addr = 6'h04; bus_wdata = 32'h2000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R9 pulse high", {31'b0, poweroff_req}, 32'h1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'b0, poweroff_req}, 32'h0);
        bus_rd(2'd1, 6'h04, rv); check("R8 suspend bit reads 0", rv, 32'h0);
        bus_wr(2'd1, 6'h04, 32'h2400);
        repeat (3) @(negedge clk);
        check("R9 type 1 no pulse", pulses, 1);

        finish_run();
    end
endmodule